// File: doc/BRIEF.md
# Mailbox Receive Overrun and Interrupt-Mask Tracker

This block keeps per-mailbox receive bookkeeping for a 32-mailbox message controller. Every mailbox has three bits: a receive-pending flag, raised when a frame lands in a receive-configured mailbox; a sticky unread flag, raised when a new frame arrives while the pending flag from an earlier frame is still set; and an interrupt mask bit. The block drives a single interrupt request. That request is the OR of all pending flags whose mask bit is clear.

A narrow 16-bit host port reaches the flags. Each function is split over two registers: a low half for mailboxes 0 to 15 and a high half for mailboxes 16 to 31. The host acknowledges pending and unread flags by writing ones. It sets the masks with plain writes. The frame engine supplies a one-cycle receive-event pulse vector and a static direction vector that marks each mailbox as transmit or receive.

Top module: `mbx_rx_track`

## Requirements
- R1: After reset all pending and unread bits are 0, all mask bits are 1, and irq_o is 0.
- R2: A receive event on a mailbox whose mbx_is_tx_i bit is 0 sets its pending bit at the next clock edge. An event on a mailbox whose mbx_is_tx_i bit is 1 leaves its pending bit unchanged.
- R3: An event sets the unread bit only if the pending bit was already 1 before that event. The first event after the host acknowledges does not set the unread bit.
- R4: An unread bit is never set for a mailbox whose mbx_is_tx_i bit is 1, even when its pending bit is still 1 from earlier.
- R5: Pending and unread bits are cleared only by a host write of 1 to their bit position. A written 0 leaves the bit unchanged.
- R6: If a host write-1-clear and a setting event hit the same pending or unread bit in the same cycle, the bit ends up set.
- R7: Mask registers are fully read/write. A mask bit of 0 enables the request from its mailbox, and a mask bit of 1 disables it.
- R8: irq_o is 1 exactly when some mailbox has pending 1 and mask 0. It is formed combinationally from the registered flags.
- R9: The register map is as follows. reg_sel_i 0/1 selects pending low/high, 2/3 selects unread low/high, and 4/5 selects mask low/high. Bit n of a low register is mailbox n, and bit n of a high register is mailbox 16+n. Selects 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_evt_i | input | 32 | One-cycle receive-event pulse, one bit per mailbox |
| mbx_is_tx_i | input | 32 | Mailbox direction, 1 = transmit, 0 = receive |
| reg_sel_i | input | 3 | Host register select |
| reg_we_i | input | 1 | Host write enable |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The host acknowledge and a new receive event can land on the same flag bit in one clock cycle. The bench creates this collision in a single cycle: it drives a write of 1 to the pending register and, in that same cycle, a receive event for the same mailbox whose pending bit is already set. It then checks that pending stays set and that the overwrite is recorded in the unread flag. A second collision pairs an unread write-1-clear with another event, and the unread bit must survive it.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;
  // upper two select bits pick the function, lower bits pick the bank
  typedef enum logic [1:0] {
    FN_PEND = 2'd0,
    FN_UNRD = 2'd1,
    FN_MASK = 2'd2,
    FN_NONE = 2'd3
  } reg_fn_e;
endpackage

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] is_tx_i,
  input  logic [W-1:0] pend_clr_i,
  input  logic [W-1:0] unrd_clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] unrd_o
);
  logic [W-1:0] pend_q, unrd_q, rx_hit;

  assign rx_hit = evt_i & ~is_tx_i;

  // set beats clear; overwrite judged on pending before this event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      unrd_q <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_i) | rx_hit;
      unrd_q <= (unrd_q & ~unrd_clr_i) | (rx_hit & pend_q);
    end
  end

  assign pend_o = pend_q;
  assign unrd_o = unrd_q;
endmodule

// File: rtl/mbx_mask_bank.sv
module mbx_mask_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mbx_reg_dec.sv
module mbx_reg_dec
  import mbx_rx_pkg::*;
#(
  parameter int NUM_BANK = 2,
  parameter int REG_W    = 16,
  parameter int BANK_W   = 1,
  parameter int SEL_W    = 3,
  localparam int TOT_W   = NUM_BANK * REG_W
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [TOT_W-1:0]    pend_i,
  input  logic [TOT_W-1:0]    unrd_i,
  input  logic [TOT_W-1:0]    mask_i,
  output logic [TOT_W-1:0]    pend_clr_o,
  output logic [TOT_W-1:0]    unrd_clr_o,
  output logic [NUM_BANK-1:0] mask_we_o,
  output logic [REG_W-1:0]    rdata_o
);
  reg_fn_e          fn;
  logic [BANK_W-1:0] bank;
  logic              bank_ok;

  always_comb begin
    fn         = reg_fn_e'(sel_i[SEL_W-1 -: 2]);
    bank       = sel_i[BANK_W-1:0];
    bank_ok    = (int'(bank) < NUM_BANK);
    pend_clr_o = '0;
    unrd_clr_o = '0;
    mask_we_o  = '0;
    rdata_o    = '0;
    if (bank_ok) begin
      unique case (fn)
        FN_PEND: begin
          rdata_o = pend_i[bank*REG_W +: REG_W];
          if (we_i) pend_clr_o[bank*REG_W +: REG_W] = wdata_i;
        end
        FN_UNRD: begin
          rdata_o = unrd_i[bank*REG_W +: REG_W];
          if (we_i) unrd_clr_o[bank*REG_W +: REG_W] = wdata_i;
        end
        FN_MASK: begin
          rdata_o = mask_i[bank*REG_W +: REG_W];
          if (we_i) mask_we_o[bank] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mbx_rx_track.sv
module mbx_rx_track #(
  parameter int NUM_MBX = 32,
  parameter int REG_W   = 16,
  localparam int NUM_BANK = NUM_MBX / REG_W,
  localparam int BANK_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int SEL_W    = BANK_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MBX-1:0] rx_evt_i,
  input  logic [NUM_MBX-1:0] mbx_is_tx_i,
  input  logic [SEL_W-1:0]   reg_sel_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_MBX-1:0]  pend_q, unrd_q, mask_q;
  logic [NUM_MBX-1:0]  pend_clr, unrd_clr;
  logic [NUM_BANK-1:0] mask_we;

  mbx_reg_dec #(
    .NUM_BANK(NUM_BANK), .REG_W(REG_W), .BANK_W(BANK_W), .SEL_W(SEL_W)
  ) u_dec (
    .sel_i     (reg_sel_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .pend_i    (pend_q),
    .unrd_i    (unrd_q),
    .mask_i    (mask_q),
    .pend_clr_o(pend_clr),
    .unrd_clr_o(unrd_clr),
    .mask_we_o (mask_we),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    mbx_flag_bank #(.W(REG_W)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (rx_evt_i[b*REG_W +: REG_W]),
      .is_tx_i   (mbx_is_tx_i[b*REG_W +: REG_W]),
      .pend_clr_i(pend_clr[b*REG_W +: REG_W]),
      .unrd_clr_i(unrd_clr[b*REG_W +: REG_W]),
      .pend_o    (pend_q[b*REG_W +: REG_W]),
      .unrd_o    (unrd_q[b*REG_W +: REG_W])
    );
    mbx_mask_bank #(.W(REG_W)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (mask_we[b]),
      .wdata_i(reg_wdata_i),
      .mask_o (mask_q[b*REG_W +: REG_W])
    );
  end

  assign irq_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/mbx_rx_track_chk.sv
module mbx_rx_track_chk #(
  parameter int NUM_MBX = 32,
  parameter int SEL_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_MBX-1:0] rx_evt_i,
  input logic [NUM_MBX-1:0] mbx_is_tx_i,
  input logic [SEL_W-1:0]   reg_sel_i,
  input logic               reg_we_i,
  input logic [NUM_MBX-1:0] pend_q,
  input logic [NUM_MBX-1:0] unrd_q,
  input logic [NUM_MBX-1:0] mask_q,
  input logic               irq_o
);
  // R2: accepted event is visible as pending one edge later
  a_r2_evt_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(rx_evt_i & ~mbx_is_tx_i) & ~pend_q) == '0));

  // R3: fresh unread bit needs an earlier pending bit plus an event
  a_r3_unrd_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((unrd_q & ~$past(unrd_q) & ~$past(pend_q & rx_evt_i)) == '0));

  // R4: transmit mailboxes never gain an unread bit
  a_r4_tx_no_unrd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((unrd_q & ~$past(unrd_q) & $past(mbx_is_tx_i)) == '0));

  // R5: an unread bit only falls after a host write to an unread register
  a_r5_unrd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(unrd_q) & ~unrd_q) != '0) |->
      ($past(reg_we_i) && ($past(reg_sel_i) >> 1) == 1));

  // R8: request tracks unmasked pending state
  a_r8_irq_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((pend_q & ~mask_q) != '0));
endmodule

bind mbx_rx_track mbx_rx_track_chk #(.NUM_MBX(NUM_MBX), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_evt_i   (rx_evt_i),
  .mbx_is_tx_i(mbx_is_tx_i),
  .reg_sel_i  (reg_sel_i),
  .reg_we_i   (reg_we_i),
  .pend_q     (pend_q),
  .unrd_q     (unrd_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/sim_mbx_rx_track.sv
`timescale 1ns/1ps
module sim_mbx_rx_track;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_evt = '0;
  logic [31:0] tx_cfg = '0;
  logic [2:0]  sel = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  mbx_rx_track u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_evt_i(rx_evt), .mbx_is_tx_i(tx_cfg),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive after negedge, release after posedge
  task automatic step(input logic [31:0] evt, input logic w, input logic [2:0] s,
                      input logic [15:0] d);
    @(negedge clk);
    rx_evt = evt; we = w; sel = s; wdata = d;
    @(posedge clk);
    #1;
    rx_evt = '0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    sel = s;
    #1;
    v = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] s, input logic [15:0] exp);
    logic [15:0] v;
    rd(s, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 pend lo", 3'd0, 16'h0000);
    expect_reg("R1 pend hi", 3'd1, 16'h0000);
    expect_reg("R1 unrd lo", 3'd2, 16'h0000);
    expect_reg("R1 unrd hi", 3'd3, 16'h0000);
    expect_reg("R1 mask lo", 3'd4, 16'hFFFF);
    expect_reg("R1 mask hi", 3'd5, 16'hFFFF);
    check("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_rx_basic;
    step(32'h0010_0008, 1'b0, 3'd0, 16'h0);
    expect_reg("R2 pend lo bit3", 3'd0, 16'h0008);
    expect_reg("R9 pend hi mbx20", 3'd1, 16'h0010);
    expect_reg("R3 no unread on first", 3'd2, 16'h0000);
    step('0, 1'b1, 3'd0, 16'h0000);
    expect_reg("R5 write 0 keeps pend", 3'd0, 16'h0008);
    step('0, 1'b1, 3'd0, 16'h0008);
    step('0, 1'b1, 3'd1, 16'h0010);
    expect_reg("R5 w1c pend lo", 3'd0, 16'h0000);
    expect_reg("R5 w1c pend hi", 3'd1, 16'h0000);
    step(32'h0000_0008, 1'b0, 3'd0, 16'h0);
    expect_reg("R3 first after ack no unread", 3'd2, 16'h0000);
    step('0, 1'b1, 3'd0, 16'h0008);
  endtask

  task automatic t_overrun;
    step(32'h0000_0020, 1'b0, 3'd0, 16'h0);
    step(32'h0000_0020, 1'b0, 3'd0, 16'h0);
    expect_reg("R3 overrun sets unread", 3'd2, 16'h0020);
    step(32'h4000_0000, 1'b0, 3'd0, 16'h0);
    step(32'h4000_0000, 1'b0, 3'd0, 16'h0);
    expect_reg("R3 overrun hi mbx30", 3'd3, 16'h4000);
    step('0, 1'b1, 3'd2, 16'h0000);
    expect_reg("R5 write 0 keeps unread", 3'd2, 16'h0020);
    step('0, 1'b1, 3'd2, 16'h0020);
    step('0, 1'b1, 3'd3, 16'h4000);
    expect_reg("R5 w1c unread lo", 3'd2, 16'h0000);
    expect_reg("R5 w1c unread hi", 3'd3, 16'h0000);
    step('0, 1'b1, 3'd0, 16'h0020);
    step('0, 1'b1, 3'd1, 16'h4000);
  endtask

  task automatic t_tx;
    tx_cfg = 32'h0002_0080;
    step(32'h0002_0080, 1'b0, 3'd0, 16'h0);
    expect_reg("R2 tx event ignored lo", 3'd0, 16'h0000);
    expect_reg("R2 tx event ignored hi", 3'd1, 16'h0000);
    // pending from receive mode, then switched to transmit
    tx_cfg = '0;
    step(32'h0000_0100, 1'b0, 3'd0, 16'h0);
    tx_cfg = 32'h0000_0100;
    step(32'h0000_0100, 1'b0, 3'd0, 16'h0);
    expect_reg("R4 tx blocks unread", 3'd2, 16'h0000);
    expect_reg("R4 pend kept", 3'd0, 16'h0100);
    tx_cfg = '0;
    step('0, 1'b1, 3'd0, 16'h0100);
  endtask

  task automatic t_collide;
    step(32'h0000_0004, 1'b0, 3'd0, 16'h0);
    step(32'h0000_0004, 1'b1, 3'd0, 16'h0004);
    expect_reg("R6 pend set wins", 3'd0, 16'h0004);
    expect_reg("R6 unread from collision", 3'd2, 16'h0004);
    step(32'h0000_0004, 1'b1, 3'd2, 16'h0004);
    expect_reg("R6 unread set wins", 3'd2, 16'h0004);
    step('0, 1'b1, 3'd2, 16'h0004);
    step('0, 1'b1, 3'd0, 16'h0004);
    expect_reg("R5 cleanup", 3'd2, 16'h0000);
  endtask

  task automatic t_mask;
    step('0, 1'b1, 3'd4, 16'hFFFB);
    expect_reg("R7 mask lo rw", 3'd4, 16'hFFFB);
    check("R8 no pend no irq", {15'd0, irq}, 16'd0);
    step(32'h4000_0000, 1'b0, 3'd0, 16'h0);
    check("R8 masked pend no irq", {15'd0, irq}, 16'd0);
    step(32'h0000_0004, 1'b0, 3'd0, 16'h0);
    check("R8 unmasked pend irq", {15'd0, irq}, 16'd1);
    step('0, 1'b1, 3'd0, 16'h0004);
    check("R8 irq drops", {15'd0, irq}, 16'd0);
    step('0, 1'b1, 3'd5, 16'hBFFF);
    expect_reg("R7 mask hi rw", 3'd5, 16'hBFFF);
    check("R7 unmask hi raises irq", {15'd0, irq}, 16'd1);
    step('0, 1'b1, 3'd5, 16'hFFFF);
    check("R7 remask drops irq", {15'd0, irq}, 16'd0);
    step('0, 1'b1, 3'd1, 16'h4000);
  endtask

  task automatic t_bad_addr;
    step(32'h0000_0001, 1'b0, 3'd0, 16'h0);
    step('0, 1'b1, 3'd6, 16'hFFFF);
    step('0, 1'b1, 3'd7, 16'h0000);
    expect_reg("R9 sel6 reads 0", 3'd6, 16'h0000);
    expect_reg("R9 sel7 reads 0", 3'd7, 16'h0000);
    expect_reg("R9 pend untouched", 3'd0, 16'h0001);
    expect_reg("R9 mask lo untouched", 3'd4, 16'hFFFB);
    expect_reg("R9 mask hi untouched", 3'd5, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_overrun();
    t_tx();
    t_collide();
    t_mask();
    t_bad_addr();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule